// File: doc/BRIEF.md
# Output Driver Impedance Update Controller

This block holds the impedance code that sets the strength of the data output drivers and moves it toward a target code. An analog comparator elsewhere produces the target from the external calibration resistor; the driver impedance should be one fifth of that resistance, for a resistor anywhere from 150 to 350 ohms. When the calibration pin is open or tied to the I/O supply, the block ignores the comparator and aims for the highest impedance the code can express.

The code drives the output stage directly, so it may change only while the data outputs are in high-Z. The memory core reports three events that open an update window. A write cycle and a deselect cycle each release the bus. An output-enable high-Z interval also opens a window, provided that the enable meets setup and hold around the clock. In each cycle that has one of these events while the bus is high-Z, the code moves exactly one step toward the target. At reset the code starts at minimum impedance, which is code zero. With the default 10-bit code, a full sweep to maximum impedance therefore takes just over a thousand update windows.

Top module: `zq_imp_ctrl`

## Requirements
- R1: After a synchronous reset, and again after any later reset, `imp_code` is 0, which means minimum impedance.
- R2: In a cycle where `dq_hiz` is 0, `imp_code` does not change at the next clock edge, whatever the other inputs are.
- R3: With `dq_hiz` high, a cycle with `wr_cyc` high moves `imp_code` one step toward the target at the next edge.
- R4: With `dq_hiz` high, a cycle with `desel_cyc` high moves `imp_code` one step toward the target at the next edge.
- R5: With `dq_hiz` high, a cycle with `oe_win` high moves `imp_code` one step toward the target at the next edge.
- R6: With `dq_hiz` high, `imp_code` holds in a cycle where none of `wr_cyc`, `desel_cyc` or `oe_win` is asserted.
- R7: Each step is exactly one code up when the target is above the current code and one code down when it is below, even when several triggers are asserted together.
- R8: When `imp_code` equals the effective target, it holds through qualifying cycles.
- R9: When `zq_open` is 1, the effective target is all ones, which means maximum impedance, and `zq_tgt_code` is ignored.
- R10: Starting from reset with the target at all ones, `imp_code` reaches all ones after exactly 2^CODE_W - 1 qualifying cycles, which is 1023 for the default, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| zq_tgt_code | input | CODE_W | Target code from the impedance comparator |
| zq_open | input | 1 | Calibration pin is open or tied high; forces the maximum target |
| dq_hiz | input | 1 | Data outputs are in high-Z this cycle |
| wr_cyc | input | 1 | Current cycle is a write |
| desel_cyc | input | 1 | Current cycle is a deselect |
| oe_win | input | 1 | Qualified output-enable high-Z update window |
| imp_code | output | CODE_W | Impedance code applied to the drivers |

## Verification
The bench gives each trigger an isolated cycle, both with the bus high-Z and with it driven. A design that forgot the high-Z gate would disturb a driving bus, and one that missed a trigger would stall there. It asserts all three triggers together to catch a design that adds them up into a multi-step jump, and it reverses the target to expose a stepper that only counts up. It walks the full range to maximum with the pin open, checking the value one step short and then at the end. This catches off-by-one sweep lengths, wraparound past all ones, and a pin-open override that still listens to the comparator code.

// File: rtl/zq_imp_pkg.sv
package zq_imp_pkg;

    localparam int unsigned IMP_CODE_W_DEF = 10;

    // trigger bundle sampled each cycle
    typedef struct packed {
        logic hiz;
        logic wr;
        logic desel;
        logic oe;
    } upd_req_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_t;

    function automatic logic any_trigger(upd_req_t r);
        return r.wr | r.desel | r.oe;
    endfunction

endpackage

// File: rtl/zq_tgt_sel.sv
module zq_tgt_sel #(
    parameter int unsigned CODE_W = 10
) (
    input  logic [CODE_W-1:0] tgt_in,
    input  logic              pin_open,
    output logic [CODE_W-1:0] tgt_eff
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    always_comb begin
        if (pin_open) tgt_eff = MAX_CODE;
        else          tgt_eff = tgt_in;
    end
endmodule

// File: rtl/zq_upd_gate.sv
module zq_upd_gate
    import zq_imp_pkg::*;
(
    input  upd_req_t req,
    output logic     upd_en
);
    always_comb begin
        upd_en = req.hiz & any_trigger(req);
    end
endmodule

// File: rtl/zq_stepper.sv
module zq_stepper
    import zq_imp_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [CODE_W-1:0] tgt,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    step_dir_t dir;

    always_comb begin
        if (tgt > code)      dir = DIR_UP;
        else if (tgt < code) dir = DIR_DOWN;
        else                 dir = DIR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (upd_en) begin
            unique case (dir)
                DIR_UP:   code <= code + ONE;
                DIR_DOWN: code <= code - ONE;
                default:  code <= code;
            endcase
        end
    end

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (code == $past(code)) || (code == $past(code) + ONE)
                 || (code == $past(code) - ONE));

    // R8
    hold_at_target_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt == code) |=> $stable(code));

    // R6
    no_trigger_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(code));
endmodule

// File: rtl/zq_imp_ctrl.sv
module zq_imp_ctrl
    import zq_imp_pkg::*;
#(
    parameter int unsigned CODE_W = IMP_CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] zq_tgt_code,
    input  logic              zq_open,
    input  logic              dq_hiz,
    input  logic              wr_cyc,
    input  logic              desel_cyc,
    input  logic              oe_win,
    output logic [CODE_W-1:0] imp_code
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    upd_req_t          req;
    logic              upd_en;
    logic [CODE_W-1:0] tgt_eff;

    always_comb begin
        req.hiz   = dq_hiz;
        req.wr    = wr_cyc;
        req.desel = desel_cyc;
        req.oe    = oe_win;
    end

    zq_tgt_sel #(.CODE_W(CODE_W)) u_tgt (
        .tgt_in   (zq_tgt_code),
        .pin_open (zq_open),
        .tgt_eff  (tgt_eff)
    );

    zq_upd_gate u_gate (
        .req    (req),
        .upd_en (upd_en)
    );

    zq_stepper #(.CODE_W(CODE_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .tgt    (tgt_eff),
        .code   (imp_code)
    );

    // R2
    driven_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_hiz |=> $stable(imp_code));

    // R9
    open_pin_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (zq_open && dq_hiz && wr_cyc && imp_code != MAX_CODE)
        |=> imp_code == $past(imp_code) + CODE_W'(1));

    // R1
    reset_min_chk: assert property (@(posedge clk)
        rst |=> imp_code == '0);
endmodule

// File: tb/zq_imp_ctrl_bench.sv
module zq_imp_ctrl_bench;
    localparam int unsigned W = 10;
    localparam logic [W-1:0] MAXC = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] zq_tgt_code;
    logic         zq_open, dq_hiz, wr_cyc, desel_cyc, oe_win;
    logic [W-1:0] imp_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    zq_imp_ctrl #(.CODE_W(W)) u_zq_imp_ctrl (
        .clk(clk), .rst(rst), .zq_tgt_code(zq_tgt_code), .zq_open(zq_open),
        .dq_hiz(dq_hiz), .wr_cyc(wr_cyc), .desel_cyc(desel_cyc),
        .oe_win(oe_win), .imp_code(imp_code)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic         hiz, wr, ds, oe, fl;
        logic [W-1:0] tgt;
        logic [W-1:0] exp;
    } vec_t;

    // walked in order from the reset value 0
    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{4'd3,  1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5, 10'd1}, // R3 write
        '{4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 10'd5, 10'd2}, // R4 deselect
        '{4'd5,  1'b1,1'b0,1'b0,1'b1,1'b0, 10'd5, 10'd3}, // R5 oe window
        '{4'd6,  1'b1,1'b0,1'b0,1'b0,1'b0, 10'd5, 10'd3}, // R6 no trigger
        '{4'd2,  1'b0,1'b1,1'b0,1'b0,1'b0, 10'd5, 10'd3}, // R2 driven write
        '{4'd2,  1'b0,1'b0,1'b1,1'b1,1'b0, 10'd0, 10'd3}, // R2 driven others
        '{4'd8,  1'b1,1'b1,1'b0,1'b0,1'b0, 10'd3, 10'd3}, // R8 at target
        '{4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 10'd0, 10'd2}, // R7 down
        '{4'd7,  1'b1,1'b1,1'b1,1'b1,1'b0, 10'd0, 10'd1}, // R7 all triggers
        '{4'd9,  1'b1,1'b1,1'b0,1'b0,1'b1, 10'd0, 10'd2}, // R9 open pin
        '{4'd2,  1'b0,1'b1,1'b1,1'b1,1'b1, 10'd0, 10'd2}  // R2 open, driven
    };

    task automatic check(input string tag, input logic [W-1:0] exp);
        checks++;
        if (imp_code !== exp) begin
            errors++;
            $display("FAIL %s: imp_code=%0d expected=%0d", tag, imp_code, exp);
        end
    endtask

    task automatic drive(input logic h, w, d, o, f, input logic [W-1:0] t);
        dq_hiz = h; wr_cyc = w; desel_cyc = d; oe_win = o; zq_open = f;
        zq_tgt_code = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset", '0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].hiz, VEC[i].wr, VEC[i].ds, VEC[i].oe, VEC[i].fl, VEC[i].tgt);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
        end

        // R1 reset again from a non-zero code
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R1 second reset", '0);

        // R10 full sweep with the pin open; the comparator code is ignored (R9)
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd7);
        repeat (int'(MAXC) - 1) @(negedge clk);
        check("R10 one short of max", MAXC - 10'd1);
        @(negedge clk);
        check("R10 reached max", MAXC);
        repeat (4) @(negedge clk);
        check("R8 holds at max", MAXC);

        // R7 reverse direction from max with a comparator target
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd100);
        @(negedge clk);
        check("R7 step down from max", MAXC - 10'd1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd100);
        repeat (3) @(negedge clk);
        check("R2 driven bus holds", MAXC - 10'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule